// File: doc/BRIEF.md
# Two-Level Memory Write Protection Unit

This unit sits between the software-visible memory write path of a small 8-bit microcontroller and its non-volatile storage: program flash, data EEPROM and an option-byte area. Every write request is classified by address and either passed on with a write-allowed flag or refused with a write-violation flag. After reset all three regions are locked. Software opens program flash or data EEPROM by writing a two-value key sequence to that region's own key register. Each region can be locked again by clearing its status flag.

A second protection level covers a boot-code area at the bottom of program flash. Its size comes from an option-byte input, counted in 64-byte pages. No key sequence opens it. Only the external programming mode input lifts both levels. That mode is also the only way to write the option byte that holds the boot size. The flash programming engine that consumes the flags is outside this block.

Top module: `wprot_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wr_allow`, `wr_violation`, `prog_unlocked` and `data_unlocked` are all 0.
- R2: The key registers are selected by `reg_sel` during a `reg_wr` strobe: 0 selects the program-flash key and 1 selects the data-EEPROM key. Writing 8'hA5 and then 8'h3C as the next two writes to a key register raises that region's unlocked flag in the cycle after the second write.
- R3: A wrong value in either key position bars that region until the next reset, including a reversed order. A correct sequence written afterwards leaves its flag at 0.
- R4: The two regions unlock independently. Key writes to one region never change the other region's flag.
- R5: A write with `reg_sel` = 2 is a status write. A 0 in bit 0 relocks program flash, and a 0 in bit 1 relocks data EEPROM. A 1 in either bit changes nothing. A relocked region can be opened again with the key sequence.
- R6: Program flash is 16'h8000 to 16'h9FFF, data EEPROM is 16'h4000 to 16'h427F, and the option area is 16'h4800 to 16'h483F. While not in external mode, a write to a locked region gives `wr_violation` = 1 and `wr_allow` = 0.
- R7: With program flash unlocked, a write whose page number ((address - 16'h8000) / 64) is at or above `boot_pages` gives `wr_allow` = 1.
- R8: A program-flash write whose page number is below `boot_pages` is refused outside external mode, even when program flash is unlocked. When `boot_pages` = 0 there is no boot region.
- R9: The option byte at 16'h4801 holds the boot size and is refused outside external mode. The other option bytes follow the data-EEPROM unlock state.
- R10: While `ext_prog` is 1, every write to a mapped region is allowed, whatever the key state or boot region.
- R11: A write outside the three regions raises neither `wr_allow` nor `wr_violation`.
- R12: For a request in cycle t, `wr_allow` or `wr_violation` is 1 in cycle t+1 only. The two flags are never both 1, and both are 0 in a cycle after no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 2 | Register select: 0 flash key, 1 EEPROM key, 2 status |
| reg_wdata | input | 8 | Control register write data |
| boot_pages | input | 8 | Boot region size in 64-byte pages, from the option byte |
| ext_prog | input | 1 | External programming mode |
| wr_req | input | 1 | Memory write request |
| wr_addr | input | 16 | Memory write address |
| wr_allow | output | 1 | Write permitted (registered, one cycle after request) |
| wr_violation | output | 1 | Write refused (registered one-cycle pulse) |
| prog_unlocked | output | 1 | Program flash first-level unlock flag |
| data_unlocked | output | 1 | Data EEPROM first-level unlock flag |

## Verification
A key or status write at a clock edge changes the unlocked flag at that same edge, so the flag is read one cycle after the write. A write request is judged against the key state from before the edge and appears on `wr_allow` or `wr_violation` exactly one cycle later. The next cycle clears it. The bench drives inputs and samples outputs on the falling edge. A behavioural model updated on each rising edge predicts all four outputs, and the bench compares them every cycle. Directed checks read each result one falling edge after its stimulus, plus one more edge to confirm that the pulse has ended.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2,
        KS_BARRED = 2'd3
    } key_state_t;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_PROG = 2'd1,
        RG_DATA = 2'd2,
        RG_OPT  = 2'd3
    } region_t;

    typedef struct packed {
        region_t region;
        logic    boot_hit;
        logic    size_byte;
    } wr_class_t;

    localparam int NUM_LANES = 2;
    localparam logic [1:0] SEL_STATUS = 2'd2;

endpackage

// File: rtl/wprot_key_fsm.sv
module wprot_key_fsm
    import wprot_pkg::*;
#(
    parameter int             DW    = 8,
    parameter logic [DW-1:0]  KEY_A = 8'hA5,
    parameter logic [DW-1:0]  KEY_B = 8'h3C
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          key_wr,
    input  logic [DW-1:0] key_data,
    input  logic          relock,
    output logic          unlocked
);

    key_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (key_wr) begin
            unique case (state_q)
                KS_LOCKED: state_d = (key_data == KEY_A) ? KS_HALF : KS_BARRED;
                KS_HALF:   state_d = (key_data == KEY_B) ? KS_OPEN : KS_BARRED;
                default:   state_d = state_q;
            endcase
        end else if (relock && state_q == KS_OPEN) begin
            state_d = KS_LOCKED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= KS_LOCKED;
        else     state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/wprot_addr_class.sv
module wprot_addr_class
    import wprot_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int CNT_W      = 8,
    parameter int PROG_BASE  = 'h8000,
    parameter int PROG_BYTES = 8192,
    parameter int DATA_BASE  = 'h4000,
    parameter int DATA_BYTES = 640,
    parameter int OPT_BASE   = 'h4800,
    parameter int OPT_BYTES  = 64,
    parameter int SIZE_OFS   = 1,
    parameter int PAGE_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  boot_pages,
    output wr_class_t         cls
);

    localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
    localparam int XW         = ADDR_W + 1;

    localparam logic [XW-1:0] PROG_LO  = XW'(PROG_BASE);
    localparam logic [XW-1:0] PROG_HI  = XW'(PROG_BASE + PROG_BYTES);
    localparam logic [XW-1:0] DATA_LO  = XW'(DATA_BASE);
    localparam logic [XW-1:0] DATA_HI  = XW'(DATA_BASE + DATA_BYTES);
    localparam logic [XW-1:0] OPT_LO   = XW'(OPT_BASE);
    localparam logic [XW-1:0] OPT_HI   = XW'(OPT_BASE + OPT_BYTES);
    localparam logic [XW-1:0] SIZE_ADR = XW'(OPT_BASE + SIZE_OFS);

    logic [XW-1:0] ax;
    logic [XW-1:0] prog_ofs;
    logic [XW-1:0] page_num;
    logic [XW-1:0] boot_ext;
    logic          in_prog, in_data, in_opt;

    always_comb begin
        ax       = {1'b0, addr};
        in_prog  = (ax >= PROG_LO) && (ax < PROG_HI);
        in_data  = (ax >= DATA_LO) && (ax < DATA_HI);
        in_opt   = (ax >= OPT_LO)  && (ax < OPT_HI);
        prog_ofs = ax - PROG_LO;
        page_num = prog_ofs >> PAGE_SHIFT;
        boot_ext = XW'(boot_pages);

        cls.region    = in_prog ? RG_PROG :
                        in_data ? RG_DATA :
                        in_opt  ? RG_OPT  : RG_NONE;
        cls.boot_hit  = in_prog && (page_num < boot_ext);
        cls.size_byte = (ax == SIZE_ADR);
    end

endmodule

// File: rtl/wprot_gate.sv
module wprot_gate
    import wprot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_req,
    input  logic      ext_prog,
    input  wr_class_t cls,
    input  logic      prog_open,
    input  logic      data_open,
    output logic      wr_allow,
    output logic      wr_violation
);

    logic permit;
    logic mapped;

    always_comb begin
        mapped = (cls.region != RG_NONE);
        unique case (cls.region)
            RG_PROG: permit = ext_prog | (prog_open & ~cls.boot_hit);
            RG_DATA: permit = ext_prog | data_open;
            RG_OPT:  permit = ext_prog | (data_open & ~cls.size_byte);
            default: permit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_allow     <= 1'b0;
            wr_violation <= 1'b0;
        end else begin
            wr_allow     <= wr_req & permit;
            wr_violation <= wr_req & mapped & ~permit;
        end
    end

endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int             ADDR_W     = 16,
    parameter int             DW         = 8,
    parameter int             CNT_W      = 8,
    parameter logic [DW-1:0]  KEY_A      = 8'hA5,
    parameter logic [DW-1:0]  KEY_B      = 8'h3C,
    parameter int             PROG_BASE  = 'h8000,
    parameter int             PROG_BYTES = 8192,
    parameter int             DATA_BASE  = 'h4000,
    parameter int             DATA_BYTES = 640,
    parameter int             OPT_BASE   = 'h4800,
    parameter int             OPT_BYTES  = 64,
    parameter int             SIZE_OFS   = 1,
    parameter int             PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [CNT_W-1:0]  boot_pages,
    input  logic              ext_prog,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_allow,
    output logic              wr_violation,
    output logic              prog_unlocked,
    output logic              data_unlocked
);

    logic [NUM_LANES-1:0] lane_open;
    wr_class_t            cls;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic key_wr;
        logic relock;
        assign key_wr = reg_wr && (reg_sel == 2'(g));
        assign relock = reg_wr && (reg_sel == SEL_STATUS) && !reg_wdata[g];

        wprot_key_fsm #(
            .DW    (DW),
            .KEY_A (KEY_A),
            .KEY_B (KEY_B)
        ) u_fsm (
            .clk      (clk),
            .rst      (rst),
            .key_wr   (key_wr),
            .key_data (reg_wdata),
            .relock   (relock),
            .unlocked (lane_open[g])
        );
    end

    wprot_addr_class #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .PROG_BASE  (PROG_BASE),
        .PROG_BYTES (PROG_BYTES),
        .DATA_BASE  (DATA_BASE),
        .DATA_BYTES (DATA_BYTES),
        .OPT_BASE   (OPT_BASE),
        .OPT_BYTES  (OPT_BYTES),
        .SIZE_OFS   (SIZE_OFS),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_class (
        .addr       (wr_addr),
        .boot_pages (boot_pages),
        .cls        (cls)
    );

    wprot_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .wr_req       (wr_req),
        .ext_prog     (ext_prog),
        .cls          (cls),
        .prog_open    (lane_open[0]),
        .data_open    (lane_open[1]),
        .wr_allow     (wr_allow),
        .wr_violation (wr_violation)
    );

    assign prog_unlocked = lane_open[0];
    assign data_unlocked = lane_open[1];

endmodule

// File: rtl/wprot_chk.sv
module wprot_chk #(
    parameter int             ADDR_W     = 16,
    parameter int             DW         = 8,
    parameter int             CNT_W      = 8,
    parameter logic [DW-1:0]  KEY_B      = 8'h3C,
    parameter int             PROG_BASE  = 'h8000,
    parameter int             PROG_BYTES = 8192,
    parameter int             DATA_BASE  = 'h4000,
    parameter int             DATA_BYTES = 640,
    parameter int             OPT_BASE   = 'h4800,
    parameter int             OPT_BYTES  = 64,
    parameter int             SIZE_OFS   = 1,
    parameter int             PAGE_BYTES = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [DW-1:0]     reg_wdata,
    input logic [CNT_W-1:0]  boot_pages,
    input logic              ext_prog,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_allow,
    input logic              wr_violation,
    input logic              prog_unlocked,
    input logic              data_unlocked
);

    int  a;
    logic in_prog, mapped, boot_req, size_req;

    always_comb begin
        a        = int'(wr_addr);
        in_prog  = (a >= PROG_BASE) && (a < PROG_BASE + PROG_BYTES);
        mapped   = in_prog
                 || ((a >= DATA_BASE) && (a < DATA_BASE + DATA_BYTES))
                 || ((a >= OPT_BASE)  && (a < OPT_BASE + OPT_BYTES));
        boot_req = in_prog && (((a - PROG_BASE) / PAGE_BYTES) < int'(boot_pages));
        size_req = (a == OPT_BASE + SIZE_OFS);
    end

    p_flags_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(wr_allow && wr_violation));

    p_no_req_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !wr_req |=> (!wr_allow && !wr_violation));

    p_unlock_needs_key_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_unlocked) |-> $past(reg_wr && reg_sel == 2'd0 && reg_wdata == KEY_B));

    p_locked_refused_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !ext_prog && in_prog && !prog_unlocked) |=> (wr_violation && !wr_allow));

    p_boot_guarded_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !ext_prog && boot_req) |=> !wr_allow);

    p_size_byte_guarded_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !ext_prog && size_req) |=> wr_violation);

    p_ext_mode_open_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_req && ext_prog && mapped) |=> wr_allow);

    p_unmapped_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !mapped) |=> (!wr_allow && !wr_violation));

endmodule

bind wprot_unit wprot_chk #(
    .ADDR_W     (ADDR_W),
    .DW         (DW),
    .CNT_W      (CNT_W),
    .KEY_B      (KEY_B),
    .PROG_BASE  (PROG_BASE),
    .PROG_BYTES (PROG_BYTES),
    .DATA_BASE  (DATA_BASE),
    .DATA_BYTES (DATA_BYTES),
    .OPT_BASE   (OPT_BASE),
    .OPT_BYTES  (OPT_BYTES),
    .SIZE_OFS   (SIZE_OFS),
    .PAGE_BYTES (PAGE_BYTES)
) u_chk (.*);

// File: tb/tb_wprot_unit.sv
module tb_wprot_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  boot_pages = 8'd0;
    logic        ext_prog = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] wr_addr = 16'h0000;
    logic        wr_allow, wr_violation, prog_unlocked, data_unlocked;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wprot_unit dut (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_sel       (reg_sel),
        .reg_wdata     (reg_wdata),
        .boot_pages    (boot_pages),
        .ext_prog      (ext_prog),
        .wr_req        (wr_req),
        .wr_addr       (wr_addr),
        .wr_allow      (wr_allow),
        .wr_violation  (wr_violation),
        .prog_unlocked (prog_unlocked),
        .data_unlocked (data_unlocked)
    );

    // Behavioural reference: 0 locked, 1 first key seen, 2 open, 3 barred
    int m_fl = 0, m_ee = 0;
    bit m_allow = 0, m_viol = 0;

    function automatic int key_step(int st, logic [7:0] d);
        if (st == 0) return (d == 8'hA5) ? 1 : 3;
        if (st == 1) return (d == 8'h3C) ? 2 : 3;
        return st;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_fl = 0; m_ee = 0; m_allow = 0; m_viol = 0;
        end else begin
            int  ad;
            bit  mp, ok;
            ad = int'(wr_addr);
            mp = 0; ok = 0;
            if (ad >= 'h8000 && ad < 'hA000) begin
                mp = 1;
                ok = ext_prog || (m_fl == 2 && ((ad - 'h8000) / 64) >= int'(boot_pages));
            end else if (ad >= 'h4000 && ad < 'h4280) begin
                mp = 1;
                ok = ext_prog || (m_ee == 2);
            end else if (ad >= 'h4800 && ad < 'h4840) begin
                mp = 1;
                ok = ext_prog || (m_ee == 2 && ad != 'h4801);
            end
            m_allow = wr_req && ok;
            m_viol  = wr_req && mp && !ok;
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: m_fl = key_step(m_fl, reg_wdata);
                    2'd1: m_ee = key_step(m_ee, reg_wdata);
                    2'd2: begin
                        if (!reg_wdata[0] && m_fl == 2) m_fl = 0;
                        if (!reg_wdata[1] && m_ee == 2) m_ee = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12: per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (wr_allow !== m_allow || wr_violation !== m_viol ||
                prog_unlocked !== (m_fl == 2) || data_unlocked !== (m_ee == 2)) begin
                fails++;
                $display("FAIL R12 model: actual allow=%b viol=%b pf=%b de=%b expected allow=%b viol=%b pf=%b de=%b",
                         wr_allow, wr_violation, prog_unlocked, data_unlocked,
                         m_allow, m_viol, (m_fl == 2), (m_ee == 2));
            end
        end
    end

    task automatic expect_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Issue one write request; result sampled one edge later, end of pulse one more edge later
    task automatic mem_write(input logic [15:0] ad, input logic exp_ok, input logic exp_bad, input string tag);
        @(negedge clk); wr_req = 1'b1; wr_addr = ad;
        @(negedge clk); wr_req = 1'b0;
        expect_bit({tag, " allow"}, wr_allow, exp_ok);
        expect_bit({tag, " violation"}, wr_violation, exp_bad);
        @(negedge clk);
        expect_bit("R12 pulse ended", wr_allow | wr_violation, 1'b0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_bit("R1 allow after reset", wr_allow, 1'b0);
        expect_bit("R1 violation after reset", wr_violation, 1'b0);
        expect_bit("R1 flash flag after reset", prog_unlocked, 1'b0);
        expect_bit("R1 eeprom flag after reset", data_unlocked, 1'b0);

        mem_write(16'h8400, 1'b0, 1'b1, "R6 locked flash");
        mem_write(16'h4010, 1'b0, 1'b1, "R6 locked eeprom");
        mem_write(16'h4805, 1'b0, 1'b1, "R6 locked option");
        mem_write(16'h0100, 1'b0, 1'b0, "R11 unmapped");
        mem_write(16'hA000, 1'b0, 1'b0, "R11 just past flash");

        // EEPROM unlock
        reg_write(2'd1, 8'hA5);
        expect_bit("R2 eeprom half key", data_unlocked, 1'b0);
        reg_write(2'd1, 8'h3C);
        expect_bit("R2 eeprom unlocked", data_unlocked, 1'b1);
        expect_bit("R4 flash untouched", prog_unlocked, 1'b0);
        mem_write(16'h427F, 1'b1, 1'b0, "R2 eeprom write");
        mem_write(16'h8400, 1'b0, 1'b1, "R4 flash still locked");
        mem_write(16'h4802, 1'b1, 1'b0, "R9 plain option byte");
        mem_write(16'h4801, 1'b0, 1'b1, "R9 size byte");

        // Relock and reopen EEPROM
        reg_write(2'd2, 8'b0000_0011);
        expect_bit("R5 ones change nothing", data_unlocked, 1'b1);
        reg_write(2'd2, 8'b0000_0001);
        expect_bit("R5 eeprom relocked", data_unlocked, 1'b0);
        mem_write(16'h4000, 1'b0, 1'b1, "R5 eeprom refused");
        reg_write(2'd1, 8'hA5);
        reg_write(2'd1, 8'h3C);
        expect_bit("R5 eeprom reopened", data_unlocked, 1'b1);

        // Flash unlock and boot region
        reg_write(2'd0, 8'hA5);
        reg_write(2'd0, 8'h3C);
        expect_bit("R2 flash unlocked", prog_unlocked, 1'b1);
        boot_pages = 8'd4;
        mem_write(16'h80FF, 1'b0, 1'b1, "R8 last boot page");
        mem_write(16'h8000, 1'b0, 1'b1, "R8 first boot page");
        mem_write(16'h8100, 1'b1, 1'b0, "R7 first open page");
        mem_write(16'h9FFF, 1'b1, 1'b0, "R7 last flash byte");
        boot_pages = 8'd0;
        mem_write(16'h8000, 1'b1, 1'b0, "R8 zero boot pages");
        boot_pages = 8'd4;
        reg_write(2'd2, 8'b0000_0010);
        expect_bit("R5 flash relocked", prog_unlocked, 1'b0);
        expect_bit("R4 eeprom kept", data_unlocked, 1'b1);

        // Wrong key handling
        do_reset();
        reg_write(2'd0, 8'h11);
        reg_write(2'd0, 8'hA5);
        reg_write(2'd0, 8'h3C);
        expect_bit("R3 wrong first key bars flash", prog_unlocked, 1'b0);
        reg_write(2'd1, 8'h3C);
        reg_write(2'd1, 8'hA5);
        reg_write(2'd1, 8'hA5);
        reg_write(2'd1, 8'h3C);
        expect_bit("R3 reversed order bars eeprom", data_unlocked, 1'b0);
        do_reset();
        reg_write(2'd0, 8'hA5);
        reg_write(2'd0, 8'h00);
        reg_write(2'd0, 8'hA5);
        reg_write(2'd0, 8'h3C);
        expect_bit("R3 wrong second key bars flash", prog_unlocked, 1'b0);

        // External programming mode
        ext_prog = 1'b1;
        mem_write(16'h8000, 1'b1, 1'b0, "R10 boot page");
        mem_write(16'h4801, 1'b1, 1'b0, "R10 size byte");
        mem_write(16'h4100, 1'b1, 1'b0, "R10 eeprom");
        mem_write(16'h2000, 1'b0, 1'b0, "R11 unmapped in ext mode");
        ext_prog = 1'b0;

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule